// File: doc/BRIEF.md
# Bimodal Instruction Width Dispatcher

This block sits between an instruction fetch buffer and a bank of eight decode slots. Each cycle it looks at a byte window that starts at the current fetch pointer. The window may hold a stream of 16-bit and 32-bit instructions. The block tests two readings of the window side by side: one that treats every 4-byte word as a full-width instruction, and one that treats every 2-byte halfword as a compressed instruction. It keeps whichever reading is consistent with the bytes. No predictor is involved, so choosing the wrong reading never costs a refetch.

When the first eight instructions all share one width and are fully present, the block issues all eight in one cycle. That is 32 bytes in wide mode and 16 bytes in narrow mode. Otherwise it falls back to a reduced path that issues up to two leading complete instructions of either width. Each cycle it reports the number of bytes it consumed, and its own fetch pointer advances by that amount. A flush clears every slot and reloads the pointer from a redirect address.

Top module: `width_dispatch`

## Requirements
- R1: When the window holds at least 32 valid bytes and every 4-byte word starting at offsets 0, 4, …, 28 is a 32-bit instruction, the next cycle presents eight valid slots. Slot k holds word k, every slot_wide bit is 1, and consumed is 32.
- R2: When the window holds at least 16 valid bytes and every halfword at offsets 0, 2, …, 14 is a 16-bit instruction, the next cycle presents eight valid slots. Slot k holds halfword k with the upper 16 bits zero, every slot_wide bit is 0, and consumed is 16.
- R3: A parcel whose lowest byte has bits [1:0] equal to 2'b11 starts a 32-bit instruction. Any other value in those bits starts a 16-bit instruction. Lengths are found by walking from byte 0, so each instruction starts where the previous one ends.
- R4: When neither full group applies, at most two leading instructions are issued, in slots 0 and 1, in stream order. Narrow ones are zero-extended. consumed equals the sum of their lengths.
- R5: An instruction whose bytes run past win_avail is never issued. If the first instruction is incomplete, the block stalls: no slot is valid and consumed is 0.
- R6: With win_valid low and no flush, the next cycle shows no valid slot and consumed 0, and the pointer holds its value.
- R7: Apart from flush, fetch_ptr advances by consumed on every cycle in which consumed is nonzero. Slots that are not valid read as zero, with their slot_wide bit also zero.
- R8: flush takes priority over a valid window. The next cycle has no valid slot, consumed is 0, and fetch_ptr equals the redirect address sampled with the flush.
- R9: Reset leaves every slot invalid, consumed at 0 and fetch_ptr at the RESET_ADDR parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Drop issue and reload pointer |
| redirect_addr | input | ADDR_W | Pointer value loaded on flush |
| win_valid | input | 1 | Window bytes are meaningful this cycle |
| win_data | input | 32*NSLOT | Fetch window, byte 0 at fetch_ptr, little-endian |
| win_avail | input | CW | Count of valid bytes from byte 0 |
| fetch_ptr | output | ADDR_W | Current fetch pointer |
| slot_insn | output | 32*NSLOT | Slot k instruction in bits [32k+31:32k] |
| slot_valid | output | NSLOT | Slot holds an issued instruction |
| slot_wide | output | NSLOT | Slot instruction is 32-bit |
| consumed | output | CW | Bytes issued this cycle |

## Verification
Flush and issue can land in the same cycle. The bench drives flush together with a full, valid window of either width. It judges the result by checking that the issue is suppressed and that the pointer takes the redirect value rather than the advanced one. A behavioural reference model that walks the window one instruction at a time is compared with every output on every clock. The model runs over directed uniform, mixed and short windows, and then over random width patterns with random valid-byte counts, gaps and flushes.

// File: rtl/width_dispatch.sv
module width_dispatch #(
  parameter int NSLOT = 8,
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
  localparam int WB = 4 * NSLOT,
  localparam int CW = $clog2(WB + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic [ADDR_W-1:0]     redirect_addr,
  input  logic                  win_valid,
  input  logic [WB*8-1:0]       win_data,
  input  logic [CW-1:0]         win_avail,
  output logic [ADDR_W-1:0]     fetch_ptr,
  output logic [NSLOT*32-1:0]   slot_insn,
  output logic [NSLOT-1:0]      slot_valid,
  output logic [NSLOT-1:0]      slot_wide,
  output logic [CW-1:0]         consumed
);

  logic [NSLOT-1:0] w_tag, n_tag;

  for (genvar k = 0; k < NSLOT; k++) begin : g_tag
    assign w_tag[k] = &win_data[32*k +: 2];
    assign n_tag[k] = ~&win_data[16*k +: 2];
  end

  wire all_wide   = &w_tag && (win_avail >= CW'(WB));
  wire all_narrow = &n_tag && (win_avail >= CW'(WB/2));

  wire          wide0 = &win_data[1:0];
  wire [CW-1:0] len0  = wide0 ? CW'(4) : CW'(2);
  wire          wide1 = &win_data[8*int'(len0) +: 2];
  wire [CW-1:0] len1  = wide1 ? CW'(4) : CW'(2);
  wire [31:0]   raw1  = win_data[8*int'(len0) +: 32];
  wire          ok0   = len0 <= win_avail;
  wire          ok1   = ok0 && (len0 + len1 <= win_avail);

  logic [NSLOT*32-1:0] n_insn;
  logic [NSLOT-1:0]    n_valid, n_wide;
  logic [CW-1:0]       n_cons;

  always_comb begin
    n_insn  = '0;
    n_valid = '0;
    n_wide  = '0;
    n_cons  = '0;
    if (all_wide) begin
      n_insn  = win_data;
      n_valid = '1;
      n_wide  = '1;
      n_cons  = CW'(WB);
    end else if (all_narrow) begin
      for (int k = 0; k < NSLOT; k++)
        n_insn[32*k +: 32] = {16'h0, win_data[16*k +: 16]};
      n_valid = '1;
      n_cons  = CW'(WB/2);
    end else begin
      if (ok0) begin
        n_valid[0]    = 1'b1;
        n_wide[0]     = wide0;
        n_insn[31:0]  = wide0 ? win_data[31:0] : {16'h0, win_data[15:0]};
        n_cons        = len0;
      end
      if (ok1) begin
        n_valid[1]    = 1'b1;
        n_wide[1]     = wide1;
        n_insn[63:32] = wide1 ? raw1 : {16'h0, raw1[15:0]};
        n_cons        = len0 + len1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_ptr  <= RESET_ADDR;
      slot_insn  <= '0;
      slot_valid <= '0;
      slot_wide  <= '0;
      consumed   <= '0;
    end else if (flush) begin
      fetch_ptr  <= redirect_addr;
      slot_insn  <= '0;
      slot_valid <= '0;
      slot_wide  <= '0;
      consumed   <= '0;
    end else if (win_valid) begin
      fetch_ptr  <= fetch_ptr + ADDR_W'(n_cons);
      slot_insn  <= n_insn;
      slot_valid <= n_valid;
      slot_wide  <= n_wide;
      consumed   <= n_cons;
    end else begin
      slot_insn  <= '0;
      slot_valid <= '0;
      slot_wide  <= '0;
      consumed   <= '0;
    end
  end

endmodule

module width_dispatch_props #(
  parameter int NSLOT = 8,
  parameter int ADDR_W = 32,
  parameter int WB = 4 * NSLOT,
  parameter int CW = $clog2(WB + 1)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                flush,
  input logic [ADDR_W-1:0]   redirect_addr,
  input logic                win_valid,
  input logic [WB*8-1:0]     win_data,
  input logic [CW-1:0]       win_avail,
  input logic [ADDR_W-1:0]   fetch_ptr,
  input logic [NSLOT*32-1:0] slot_insn,
  input logic [NSLOT-1:0]    slot_valid,
  input logic [NSLOT-1:0]    slot_wide,
  input logic [CW-1:0]       consumed
);

  p_full_wide_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (&slot_valid && slot_wide[0]) |-> (consumed == CW'(WB) && &slot_wide));

  p_full_narrow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (&slot_valid && !slot_wide[0]) |-> (consumed == CW'(WB/2) && slot_wide == '0));

  p_reduced_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_valid != '1) |-> ($countones(slot_valid) <= 2 && (slot_valid & (slot_valid + 1'b1)) == '0));

  p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_valid && !flush) |=> (slot_valid == '0 && consumed == '0 && $stable(fetch_ptr)));

  p_ptr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(flush)) |-> fetch_ptr == $past(fetch_ptr) + ADDR_W'(consumed));

  p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (slot_valid == '0 && consumed == '0 && fetch_ptr == $past(redirect_addr)));

endmodule

bind width_dispatch width_dispatch_props #(.NSLOT(NSLOT), .ADDR_W(ADDR_W)) u_props (.*);

// File: tb/width_dispatch_test.sv
`timescale 1ns/1ps
module width_dispatch_test;
  localparam int NSLOT = 8;
  localparam int ADDR_W = 32;
  localparam int WB = 4 * NSLOT;
  localparam int CW = $clog2(WB + 1);
  localparam logic [31:0] RST_PC = 32'h0000_1000;

  logic clk = 0, rst_n = 0, flush = 0, win_valid = 0;
  logic [ADDR_W-1:0] redirect_addr = '0;
  logic [WB*8-1:0] win_data = '0;
  logic [CW-1:0] win_avail = '0;
  logic [ADDR_W-1:0] fetch_ptr;
  logic [NSLOT*32-1:0] slot_insn;
  logic [NSLOT-1:0] slot_valid, slot_wide;
  logic [CW-1:0] consumed;

  width_dispatch #(.NSLOT(NSLOT), .ADDR_W(ADDR_W), .RESET_ADDR(RST_PC)) uut (.*);

  always #4 clk = ~clk;

  int errors = 0, checks = 0;
  bit done = 0;
  byte unsigned win [WB];
  logic [ADDR_W-1:0] e_ptr;
  logic [NSLOT*32-1:0] e_insn;
  logic [NSLOT-1:0] e_valid, e_wide;
  int e_cons;

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model();
    int lens[8];
    int off = 0, n = 0, cnt;
    bit uni;
    e_valid = '0; e_wide = '0; e_insn = '0; e_cons = 0;
    if (flush) begin e_ptr = redirect_addr; return; end
    if (!win_valid) return;
    while (n < 8) begin
      int l = ((win[off] & 3) == 3) ? 4 : 2;
      if (off + l > int'(win_avail)) break;
      lens[n] = l; off += l; n++;
    end
    uni = (n == 8);
    for (int i = 0; i < n; i++) if (lens[i] != lens[0]) uni = 0;
    cnt = uni ? 8 : (n < 2 ? n : 2);
    off = 0;
    for (int i = 0; i < cnt; i++) begin
      logic [31:0] w = 0;
      for (int b = 0; b < lens[i]; b++) w[8*b +: 8] = win[off + b];
      e_insn[32*i +: 32] = w;
      e_valid[i] = 1;
      e_wide[i] = (lens[i] == 4);
      off += lens[i];
    end
    e_cons = off;
    e_ptr = e_ptr + off;
  endtask

  // kinds bit k: instruction k of the walk is wide (R3 tag rule)
  task automatic build(int unsigned kinds);
    int off = 0, k = 0;
    for (int i = 0; i < WB; i++) win[i] = byte'($urandom);
    while (off < WB) begin
      bit w = kinds[k % 32];
      if (w) win[off] = win[off] | 8'h03;
      else win[off] = (win[off] & 8'hFC) | byte'($urandom_range(0, 2));
      off += w ? 4 : 2; k++;
    end
    for (int i = 0; i < WB; i++) win_data[8*i +: 8] = win[i];
  endtask

  task automatic step(string req, bit v, int avail, bit fl, logic [31:0] redir);
    @(negedge clk);
    win_valid = v; win_avail = CW'(avail); flush = fl; redirect_addr = redir;
    model();
    @(posedge clk); #1;
    chk(req, "slot_valid", slot_valid, e_valid);
    chk(req, "slot_wide", slot_wide, e_wide);
    chk(req, "slot_insn_lo", slot_insn[127:0] == e_insn[127:0], 1);
    chk(req, "slot_insn_hi", slot_insn[255:128] == e_insn[255:128], 1);
    chk(req, "consumed", consumed, e_cons);
    chk({req, "/R7"}, "fetch_ptr", fetch_ptr, e_ptr);
  endtask

  initial begin
    #1500000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog all-requirements actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    e_ptr = RST_PC;
    repeat (3) @(posedge clk);
    #1;
    chk("R9", "slot_valid", slot_valid, 0);
    chk("R9", "consumed", consumed, 0);
    chk("R9", "fetch_ptr", fetch_ptr, RST_PC);
    @(negedge clk); rst_n = 1;

    build(32'hFFFF_FFFF); step("R1", 1, 32, 0, 0);
    build(32'h0);         step("R2", 1, 32, 0, 0);
    build(32'h0);         step("R2", 1, 16, 0, 0);
    build(32'h0000_0002); step("R4", 1, 32, 0, 0);  // narrow then wide
    build(32'h0000_0001); step("R4", 1, 32, 0, 0);  // wide then narrow
    build(32'h0000_00F3); step("R3", 1, 32, 0, 0);
    build(32'hFFFF_FFFF); step("R5", 1, 20, 0, 0);  // short wide window
    build(32'hFFFF_FFFF); step("R5", 1, 3, 0, 0);   // stall
    build(32'h0);         step("R5", 1, 1, 0, 0);   // stall
    build(32'hFFFF_FFFE); step("R5", 1, 5, 0, 0);   // one narrow only
    build(32'hFFFF_FFFF); step("R6", 0, 32, 0, 0);
    build(32'hFFFF_FFFF); step("R8", 1, 32, 1, 32'h0000_8000);
    build(32'h0);         step("R8", 1, 32, 1, 32'h0000_A002);
    build(32'h0);         step("R7", 1, 32, 0, 0);

    for (int it = 0; it < 600; it++) begin
      int r = $urandom_range(0, 3);
      int unsigned kinds = (r == 0) ? 32'h0 : (r == 1) ? 32'hFFFF_FFFF : $urandom;
      int avail = ($urandom_range(0, 2) == 0) ? $urandom_range(0, 32) : 32;
      bit v = ($urandom_range(0, 9) != 0);
      bit fl = ($urandom_range(0, 19) == 0);
      build(kinds);
      step("R4", v, avail, fl, $urandom & 32'hFFFF_FFFE);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule